// File: doc/BRIEF.md
# Qualified Rising-Edge Latch with Unit-Distance States

This block watches two level inputs, a qualifier `x_in` and a trigger `y_in`. It drives one output, `z_out`. The output is raised when the trigger goes from low to high while the qualifier is already high. It then stays high for as long as the qualifier stays high, whatever the trigger does meanwhile. If the trigger is already high when the qualifier rises, the output is not raised. The trigger must first drop with the qualifier high and then rise again.

The block is a clocked model of a self-timed controller. Each input passes through its own synchronizer chain, `SYNC_STAGES` flops deep. A two-bit state register then steps through four codes: idle 00, armed 01, active 11 and drain 10. Each code differs from the next in a single bit. The drain code sits on the way back from active to idle, so no transition ever flips both bits at once. The output is 1 in the active and drain codes.

The inputs are expected never to change in the same clock cycle.

Top module: `qual_edge_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the state is forced to idle (00) and all synchronizer flops are cleared. After reset `z_out` reads 0.
- R2: From idle, `x_in`=1 with `y_in`=0 arms the block. A later rise of `y_in` then sets `z_out` exactly `SYNC_STAGES`+1 clock edges after the input change (3 edges with the default of 2).
- R3: A rise of `y_in` while `x_in` is 0 never sets `z_out`.
- R4: If `y_in` is already 1 when `x_in` rises, `z_out` stays 0. The block waits in idle until `y_in` drops.
- R5: While `z_out` is 1 and `x_in` stays 1, toggling `y_in` leaves `z_out` at 1.
- R6: When `x_in` falls while `z_out` is 1, `z_out` is still 1 `SYNC_STAGES`+1 edges after the change. It is 0 one edge later.
- R7: When `x_in` falls while armed, the block returns to idle. A following rise of `y_in` with `x_in` low does not set `z_out`.
- R8: Every change of the state register flips exactly one of its two bits.
- R9: The drain state (10) is left for idle (00) on the very next clock edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all flops update on its rising edge |
| rst | input | 1 | Active-high synchronous reset |
| x_in | input | 1 | Qualifier level input, asynchronous to `clk` |
| y_in | input | 1 | Trigger level input, asynchronous to `clk` |
| z_out | output | 1 | Output; 1 in the active and drain states |

## Verification
The hardest case to reach is the one where the trigger is already high when the qualifier rises. The block must then stay idle until the trigger drops and rises again. A random walk only rarely produces that exact order followed by a clean re-arm. A directed sequence therefore builds it step by step and then checks the set latency to the exact edge. The return path through the drain state only shows at the ports as a one-edge lag in the fall of `z_out`, so the qualifier fall is sampled on both sides of that edge. A seeded random walk then toggles one input at a time and compares the settled output with a three-state behavioural model.

// File: rtl/qedge_pkg.sv
package qedge_pkg;
   // Unit-distance state codes; neighbouring codes differ in one bit.
   typedef enum logic [1:0] {
      QE_IDLE   = 2'b00,
      QE_ARMED  = 2'b01,
      QE_ACTIVE = 2'b11,
      QE_DRAIN  = 2'b10
   } qe_state_t;

   // Output decode: high in the two states with the upper bit set.
   function automatic logic qe_out(input qe_state_t s);
      return (s == QE_ACTIVE) || (s == QE_DRAIN);
   endfunction
endpackage

// File: rtl/qe_sync_chain.sv
module qe_sync_chain #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("qe_sync_chain: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("qe_sync_chain: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] pipe;
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= d[b];
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], d[b]};
         end
      end
      assign q[b] = pipe[STAGES-1];
   end
endmodule

// File: rtl/qe_fsm_core.sv
module qe_fsm_core
   import qedge_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      x,
   input  logic      y,
   output qe_state_t st
);
   qe_state_t st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         QE_IDLE:   if (x && !y) st_nx = QE_ARMED;
         QE_ARMED: begin
            if (!x)     st_nx = QE_IDLE;
            else if (y) st_nx = QE_ACTIVE;
         end
         QE_ACTIVE: if (!x) st_nx = QE_DRAIN;
         QE_DRAIN:  st_nx = QE_IDLE;
         default:   st_nx = QE_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= QE_IDLE;
      else     st <= st_nx;
   end
endmodule

// File: rtl/qual_edge_fsm.sv
module qual_edge_fsm
   import qedge_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic x_in,
   input  logic y_in,
   output logic z_out
);
   localparam int NUM_IN = 2;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("qual_edge_fsm: SYNC_STAGES must be at least 1");
   end

   logic [NUM_IN-1:0] raw_in;
   logic [NUM_IN-1:0] sync_in;
   logic              x_s;
   logic              y_s;
   qe_state_t         st;

   assign raw_in = {y_in, x_in};

   qe_sync_chain #(
      .WIDTH  (NUM_IN),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in),
      .q   (sync_in)
   );

   assign x_s = sync_in[0];
   assign y_s = sync_in[1];

   qe_fsm_core u_core (
      .clk (clk),
      .rst (rst),
      .x   (x_s),
      .y   (y_s),
      .st  (st)
   );

   assign z_out = qe_out(st);
endmodule

// File: rtl/qual_edge_fsm_chk.sv
module qual_edge_fsm_chk (
   input logic       clk,
   input logic       rst,
   input logic [1:0] st,
   input logic       x_s,
   input logic       y_s,
   input logic       z_out
);
   // R8
   unit_dist_chk: assert property (@(posedge clk) disable iff (rst)
      (st != $past(st)) |-> ($countones(st ^ $past(st)) == 1));

   // R9
   drain_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 2'b10) |=> (st == 2'b00));

   // R2
   set_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(z_out) |-> ($past(x_s) && $past(y_s) && $past(st) == 2'b01));

   // R4
   arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(st) == 2'b00 && st == 2'b01) |-> ($past(x_s) && !$past(y_s)));

   // R6
   drain_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 2'b10) |-> !$past(x_s));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(st) == 2'b11 && $past(x_s)) |-> (st == 2'b11));

   // R7
   disarm_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(st) == 2'b01 && !$past(x_s)) |-> (st == 2'b00));
endmodule

bind qual_edge_fsm qual_edge_fsm_chk u_chk (
   .clk   (clk),
   .rst   (rst),
   .st    (st),
   .x_s   (x_s),
   .y_s   (y_s),
   .z_out (z_out)
);

// File: tb/sim_qual_edge_fsm.sv
`timescale 1ns/1ps
module sim_qual_edge_fsm;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x_in = 1'b0;
   logic y_in = 1'b0;
   logic z_out;

   int n_tests = 0;
   int n_fail  = 0;
   int mstate  = 0;   // 0 idle, 1 armed, 2 active

   always #5 clk = ~clk;

   qual_edge_fsm #(.SYNC_STAGES(2)) u0 (
      .clk   (clk),
      .rst   (rst),
      .x_in  (x_in),
      .y_in  (y_in),
      .z_out (z_out)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic exp);
      n_tests++;
      if (z_out !== exp) begin
         n_fail++;
         $display("FAIL %s: z_out=%b expected %b at %0t", req, z_out, exp, $time);
      end
   endtask

   function automatic int model_next(input int s, input logic x, input logic y);
      case (s)
         0:       return (x && !y) ? 1 : 0;
         1:       return !x ? 0 : (y ? 2 : 1);
         default: return x ? 2 : 0;
      endcase
   endfunction

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4177));
      @(negedge clk);
      tick(4);
      rst = 1'b0;
      // R1: reset leaves the output low
      check("R1", 1'b0);
      tick(3);
      check("R1", 1'b0);

      // R3: trigger rise with qualifier low
      y_in = 1'b1; tick(5); check("R3", 1'b0);
      y_in = 1'b0; tick(5); check("R3", 1'b0);

      // R4: trigger already high when qualifier rises
      y_in = 1'b1; tick(5);
      x_in = 1'b1; tick(5); check("R4", 1'b0);
      tick(5);              check("R4", 1'b0);

      // R2: drop trigger to arm, then the rise sets after 3 edges
      y_in = 1'b0; tick(5); check("R2", 1'b0);
      y_in = 1'b1; tick(2); check("R2", 1'b0);
      tick(1);              check("R2", 1'b1);

      // R5: trigger toggles while qualifier held high
      y_in = 1'b0; tick(5); check("R5", 1'b1);
      y_in = 1'b1; tick(5); check("R5", 1'b1);
      y_in = 1'b0; tick(1); check("R5", 1'b1);
      tick(4);              check("R5", 1'b1);

      // R6 and R9: qualifier fall; output lags one edge for the drain state
      x_in = 1'b0; tick(3); check("R6", 1'b1);
      tick(1);              check("R9", 1'b0);
      tick(3);              check("R6", 1'b0);

      // R7: qualifier falls while armed
      x_in = 1'b1; tick(5); check("R7", 1'b0);
      x_in = 1'b0; tick(5); check("R7", 1'b0);
      y_in = 1'b1; tick(5); check("R7", 1'b0);
      x_in = 1'b1; tick(5); check("R7", 1'b0);
      x_in = 1'b0; tick(5);
      y_in = 1'b0; tick(5); check("R7", 1'b0);

      // Random walk, one input toggle per step; R8 holds on every transition
      mstate = 0;
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(1, 0) == 1) x_in = ~x_in;
         else                           y_in = ~y_in;
         mstate = model_next(mstate, x_in, y_in);
         tick(5);
         check("R2/R3/R4/R5/R6/R7/R8 random", (mstate == 2) ? 1'b1 : 1'b0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule